// File: doc/BRIEF.md
# Multithreaded Issue Thread Selector

This block sits in front of a single instruction pipeline that is shared by several hardware thread contexts. On every clock it decides which context supplies the next instruction. It also reports whether that choice is a real issue slot and whether the selected context differs from the one chosen before. It looks only at three flags per thread: ready, a short stall (for example a data hazard) and a long stall (for example a second-level cache miss). The register files, program counters and the pipeline stay outside the block.

A mode input picks one of two policies. In the fine-grain policy the selector moves to a different thread on every cycle and passes over any thread that cannot issue. In the coarse-grain policy it stays with one thread. A short stall costs that issue slot. Only a long stall makes it move to another thread, and that move costs a fixed number of refill bubbles. In both policies the block keeps one pointer. It holds the thread issued last, or the current thread. The next search starts at the thread after it.

All outputs are registered. A decision that is based on the flags sampled at one rising edge appears on the outputs right after that edge.

Top module: `mt_issue_sel`

## Requirements
- R1: While reset is asserted and right after it, issue_valid_o and issue_switch_o are 0 and issue_tid_o equals N_THR-1 (for the default, 3).
- R2: A thread is eligible when its bit in ready_i is 1 and its bits in short_stall_i and long_stall_i are both 0. Bit i belongs to thread i. In fine mode (mode_i = 0) the block issues the first eligible thread found in the order pointer+1, pointer+2, …, wrapping past N_THR-1 to 0. The pointer is the value on issue_tid_o.
- R3: In fine mode a thread that is not ready, short-stalled or long-stalled is skipped, and the next eligible thread in the rotation issues in its place.
- R4: In fine mode issue_switch_o is 1 exactly when the issued thread differs from the previous issue_tid_o. When one eligible thread is the only one left, it issues again with issue_switch_o at 0.
- R5: When no thread can be chosen, issue_valid_o and issue_switch_o are 0 and issue_tid_o keeps its value.
- R6: In coarse mode (mode_i = 1) the current thread, shown on issue_tid_o, keeps issuing for as long as it is eligible, even while other threads are ready.
- R7: In coarse mode, if the current thread is short-stalled or not ready and has no long stall, the slot is lost: issue_valid_o is 0, issue_switch_o is 0 and issue_tid_o is unchanged.
- R8: In coarse mode, a long stall on the current thread moves the selection to the next eligible thread in rotation order after it. In that cycle issue_switch_o is 1, issue_valid_o is 0 and issue_tid_o shows the new thread.
- R9: A coarse switch costs REFILL cycles with issue_valid_o at 0 in total, counting the switch cycle. During the bubbles after the switch cycle, stall flags are ignored and the thread does not change. Issue then resumes on the new thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 selects fine-grain rotation, 1 selects coarse-grain switching |
| ready_i | input | N_THR | Per-thread ready flags |
| short_stall_i | input | N_THR | Per-thread short-stall flags |
| long_stall_i | input | N_THR | Per-thread long-stall flags |
| issue_tid_o | output | TID_W | Selected or current thread index |
| issue_valid_o | output | 1 | The selected thread issues in this slot |
| issue_switch_o | output | 1 | The selected thread differs from the previous one |

## Verification
The bound checker checks these properties on every cycle:
- an issued thread was eligible at the deciding edge;
- fine mode never repeats a thread while another was eligible;
- with no eligible thread the outputs stay silent and the thread index holds;
- a coarse switch happens only after a long stall on the current thread, and it opens at least two bubbles.

Some behaviour only the bench's directed scenarios can show:
- the exact rotation order and the wrap-around;
- the choice of the thread that replaces a stalled one;
- the bubble count;
- the fact that flags are ignored during refill;
- the reset value of the pointer.

// File: rtl/mt_sel_pkg.sv
package mt_sel_pkg;

    typedef enum logic {
        SEL_FINE   = 1'b0,
        SEL_COARSE = 1'b1
    } sel_mode_e;

endpackage

// File: rtl/mt_rr_pick.sv
// Rotating priority search: first requesting index after 'last', wrapping.
module mt_rr_pick #(
    parameter int N_THR = 4,
    localparam int TID_W = (N_THR > 1) ? $clog2(N_THR) : 1
) (
    input  logic [N_THR-1:0] req_i,
    input  logic [TID_W-1:0] last_i,
    output logic             found_o,
    output logic [TID_W-1:0] idx_o
);
    logic [N_THR-1:0] rot_req;
    logic [TID_W-1:0] rot_idx [N_THR];

    // rot_req[k] is the request of the thread k+1 places after 'last'
    for (genvar k = 0; k < N_THR; k++) begin : g_rot
        always_comb begin
            rot_idx[k] = TID_W'((int'(last_i) + k + 1) % N_THR);
            rot_req[k] = req_i[rot_idx[k]];
        end
    end

    always_comb begin
        found_o = 1'b0;
        idx_o   = last_i;
        for (int k = 0; k < N_THR; k++) begin
            if (!found_o && rot_req[k]) begin
                found_o = 1'b1;
                idx_o   = rot_idx[k];
            end
        end
    end

endmodule

// File: rtl/mt_refill_ctr.sv
// Counts remaining refill bubbles after a coarse-grain switch.
module mt_refill_ctr #(
    parameter int REFILL = 2,
    localparam int CNT_W = $clog2(REFILL + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic load_i,
    output logic busy_o
);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(REFILL - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (load_i) begin
            cnt_d = LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/mt_issue_sel.sv
module mt_issue_sel
    import mt_sel_pkg::*;
#(
    parameter int N_THR  = 4,
    parameter int REFILL = 2,
    localparam int TID_W = (N_THR > 1) ? $clog2(N_THR) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_i,
    input  logic [N_THR-1:0] ready_i,
    input  logic [N_THR-1:0] short_stall_i,
    input  logic [N_THR-1:0] long_stall_i,
    output logic [TID_W-1:0] issue_tid_o,
    output logic             issue_valid_o,
    output logic             issue_switch_o
);
    localparam logic [TID_W-1:0] TID_RST = TID_W'(N_THR - 1);

    typedef struct packed {
        logic [TID_W-1:0] tid;
        logic             valid;
        logic             sw;
    } sel_st_t;

    sel_st_t          st_d, st_q;
    sel_mode_e        mode;
    logic [N_THR-1:0] elig;
    logic             pick_found;
    logic [TID_W-1:0] pick_idx;
    logic             refill_busy;
    logic             refill_load;

    assign mode = sel_mode_e'(mode_i);
    assign elig = ready_i & ~short_stall_i & ~long_stall_i;

    mt_rr_pick #(.N_THR(N_THR)) u_pick (
        .req_i   (elig),
        .last_i  (st_q.tid),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    mt_refill_ctr #(.REFILL(REFILL)) u_refill (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (mode == SEL_FINE),
        .load_i  (refill_load),
        .busy_o  (refill_busy)
    );

    always_comb begin
        st_d        = st_q;
        st_d.valid  = 1'b0;
        st_d.sw     = 1'b0;
        refill_load = 1'b0;
        if (mode == SEL_FINE) begin
            if (pick_found) begin
                st_d.tid   = pick_idx;
                st_d.valid = 1'b1;
                st_d.sw    = (pick_idx != st_q.tid);
            end
        end else if (!refill_busy) begin
            if (long_stall_i[st_q.tid]) begin
                if (pick_found) begin
                    st_d.tid    = pick_idx;
                    st_d.sw     = 1'b1;
                    refill_load = 1'b1;
                end
            end else if (elig[st_q.tid]) begin
                st_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tid   <= TID_RST;
            st_q.valid <= 1'b0;
            st_q.sw    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign issue_tid_o    = st_q.tid;
    assign issue_valid_o  = st_q.valid;
    assign issue_switch_o = st_q.sw;

endmodule

// File: rtl/mt_issue_sel_chk.sv
module mt_issue_sel_chk #(
    parameter int N_THR  = 4,
    parameter int REFILL = 2,
    localparam int TID_W = (N_THR > 1) ? $clog2(N_THR) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_i,
    input logic [N_THR-1:0] ready_i,
    input logic [N_THR-1:0] short_stall_i,
    input logic [N_THR-1:0] long_stall_i,
    input logic [TID_W-1:0] issue_tid_o,
    input logic             issue_valid_o,
    input logic             issue_switch_o
);
    logic [N_THR-1:0] elig_prev_q;
    logic [N_THR-1:0] long_prev_q;
    logic             mode_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elig_prev_q <= '0;
            long_prev_q <= '0;
            mode_prev_q <= 1'b0;
        end else begin
            elig_prev_q <= ready_i & ~short_stall_i & ~long_stall_i;
            long_prev_q <= long_stall_i;
            mode_prev_q <= mode_i;
        end
    end

    assert_issue_eligible_R3: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid_o |-> elig_prev_q[issue_tid_o]);

    assert_fine_rotates_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid_o && !mode_prev_q && $countones(elig_prev_q) > 1)
            |-> (issue_tid_o != $past(issue_tid_o)));

    assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (elig_prev_q == '0) |-> (!issue_valid_o && !issue_switch_o && $stable(issue_tid_o)));

    assert_coarse_switch_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_switch_o && mode_prev_q)
            |-> (!issue_valid_o && long_prev_q[$past(issue_tid_o)]));

    assert_short_no_switch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_prev_q && !long_prev_q[$past(issue_tid_o)]) |-> !issue_switch_o);

    if (REFILL >= 2) begin : g_refill
        assert_refill_bubble_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(issue_switch_o) && $past(mode_i, 2) && mode_prev_q)
                |-> (!issue_valid_o && $stable(issue_tid_o)));
    end

endmodule

bind mt_issue_sel mt_issue_sel_chk #(.N_THR(N_THR), .REFILL(REFILL)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode_i         (mode_i),
    .ready_i        (ready_i),
    .short_stall_i  (short_stall_i),
    .long_stall_i   (long_stall_i),
    .issue_tid_o    (issue_tid_o),
    .issue_valid_o  (issue_valid_o),
    .issue_switch_o (issue_switch_o)
);

// File: tb/mt_issue_sel_tb.sv
module mt_issue_sel_tb;
    localparam int N_THR  = 4;
    localparam int REFILL = 2;
    localparam int NV     = 19;

    // {mode, ready[3:0], short[3:0], long[3:0], exp_valid, exp_tid[1:0], exp_switch}
    localparam logic [16:0] VEC [NV] = '{
        {1'b0, 4'b1111, 4'b0000, 4'b0000, 1'b1, 2'd0, 1'b1},  // R2 from reset pointer 3 -> 0
        {1'b0, 4'b1111, 4'b0000, 4'b0000, 1'b1, 2'd1, 1'b1},  // R2
        {1'b0, 4'b1111, 4'b0100, 4'b0000, 1'b1, 2'd3, 1'b1},  // R3 short skip
        {1'b0, 4'b1111, 4'b0000, 4'b0001, 1'b1, 2'd1, 1'b1},  // R3 long skip, wrap
        {1'b0, 4'b0010, 4'b0000, 4'b0000, 1'b1, 2'd1, 1'b0},  // R4 lone thread repeats
        {1'b0, 4'b0000, 4'b0000, 4'b0000, 1'b0, 2'd1, 1'b0},  // R5 none eligible
        {1'b0, 4'b1000, 4'b0000, 4'b0000, 1'b1, 2'd3, 1'b1},  // R2
        {1'b1, 4'b1111, 4'b0000, 4'b0000, 1'b1, 2'd3, 1'b0},  // R6
        {1'b1, 4'b1111, 4'b0000, 4'b0000, 1'b1, 2'd3, 1'b0},  // R6
        {1'b1, 4'b1111, 4'b1000, 4'b0000, 1'b0, 2'd3, 1'b0},  // R7 short stall
        {1'b1, 4'b0111, 4'b0000, 4'b0000, 1'b0, 2'd3, 1'b0},  // R7 not ready
        {1'b1, 4'b1111, 4'b0000, 4'b1000, 1'b0, 2'd0, 1'b1},  // R8 long stall switch
        {1'b1, 4'b1111, 4'b0000, 4'b0001, 1'b0, 2'd0, 1'b0},  // R9 bubble ignores stall
        {1'b1, 4'b1111, 4'b0000, 4'b0000, 1'b1, 2'd0, 1'b0},  // R9 resumes
        {1'b1, 4'b1111, 4'b0010, 4'b0001, 1'b0, 2'd2, 1'b1},  // R8 skips short thread
        {1'b1, 4'b1111, 4'b0000, 4'b0000, 1'b0, 2'd2, 1'b0},  // R9 bubble
        {1'b1, 4'b1111, 4'b0000, 4'b0000, 1'b1, 2'd2, 1'b0},  // R9 resumes
        {1'b1, 4'b1111, 4'b0000, 4'b1111, 1'b0, 2'd2, 1'b0},  // R5 long, nowhere to go
        {1'b0, 4'b1111, 4'b0000, 4'b0000, 1'b1, 2'd3, 1'b1}   // R2 back to fine
    };
    localparam int VREQ [NV] = '{2, 2, 3, 3, 4, 5, 2, 6, 6, 7, 7, 8, 9, 9, 8, 9, 9, 5, 2};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_i = 1'b0;
    logic [N_THR-1:0] ready_i = '0;
    logic [N_THR-1:0] short_stall_i = '0;
    logic [N_THR-1:0] long_stall_i = '0;
    logic [1:0]       issue_tid_o;
    logic             issue_valid_o;
    logic             issue_switch_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    mt_issue_sel #(.N_THR(N_THR), .REFILL(REFILL)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_i         (mode_i),
        .ready_i        (ready_i),
        .short_stall_i  (short_stall_i),
        .long_stall_i   (long_stall_i),
        .issue_tid_o    (issue_tid_o),
        .issue_valid_o  (issue_valid_o),
        .issue_switch_o (issue_switch_o)
    );

    task automatic check(input string req, input logic ev, input logic [1:0] et, input logic es);
        checks++;
        if (issue_valid_o !== ev || issue_tid_o !== et || issue_switch_o !== es) begin
            errors++;
            $display("FAIL %s: got valid=%0b tid=%0d switch=%0b, expected valid=%0b tid=%0d switch=%0b",
                     req, issue_valid_o, issue_tid_o, issue_switch_o, ev, et, es);
        end
    endtask

    task automatic step(input logic m, input logic [3:0] r, input logic [3:0] s, input logic [3:0] l);
        mode_i = m; ready_i = r; short_stall_i = s; long_stall_i = l;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", 1'b0, 2'd3, 1'b0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][16], VEC[i][15:12], VEC[i][11:8], VEC[i][7:4]);
            check($sformatf("R%0d vector %0d", VREQ[i], i), VEC[i][3], VEC[i][2:1], VEC[i][0]);
        end
        // R1: reset in the middle of a run
        rst_n = 1'b0;
        #1;
        check("R1 mid-run reset", 1'b0, 2'd3, 1'b0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R6: coarse mode out of reset keeps thread 3
        step(1'b1, 4'b1111, 4'b0000, 4'b0000);
        check("R6 coarse from reset", 1'b1, 2'd3, 1'b0);
        // R8: long stall on thread 3 with thread 0 not ready picks thread 1
        step(1'b1, 4'b1110, 4'b0000, 4'b1000);
        check("R8 wrap to next eligible", 1'b0, 2'd1, 1'b1);
        // R9: long stall on the new thread during refill is ignored
        step(1'b1, 4'b1111, 4'b0000, 4'b0010);
        check("R9 refill bubble", 1'b0, 2'd1, 1'b0);
        step(1'b1, 4'b1111, 4'b0000, 4'b0000);
        check("R9 issue after refill", 1'b1, 2'd1, 1'b0);
        // R4: fine mode with all ready switches each cycle
        step(1'b0, 4'b1111, 4'b0000, 4'b0000);
        check("R4 fine switch", 1'b1, 2'd2, 1'b1);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule